// File: doc/BRIEF.md
# MAC-Counting Context Switch Generator

This block tracks how many multiply-accumulate operations the systolic array has performed in the current context. It counts them by modelling the corner processing element. A cycle counts as one MAC only when the pipeline is enabled and the operands are not being forced to zero by a soft stall. When the count reaches the programmed number of MACs per context, the block raises a context-done flag toward the context controller. It keeps that flag raised until the controller allows the switch.

Once the controller asserts the switch enable while the flag is up, the block sends a single-cycle switch pulse into the array entry. That pulse makes each processing element exchange its accumulator with its reserve register. The block then holds a busy indication while the switch ripples across the array. The busy interval covers ROWS+COLS-1 pipeline-enabled cycles. When the switch starts, the MAC counter returns to zero and begins counting the next context. A synchronous clear drops any count, any pending flag and any ongoing switch.

Top module: `ctx_switch_gen`

## Requirements
- R1: After an asynchronous reset (rst_ni low), cdone_o, sw_pulse_o and sw_busy_o are all 0.
- R2: A cycle counts as a MAC only when pipe_en_i=1 and soft_stall_i=0. cdone_o rises in the cycle after the edge at which the macs_i-th such cycle is counted.
- R3: Once cdone_o is 1, it stays 1 until a switch starts or clear_i is applied. Further MAC cycles do not alter it.
- R4: A switch starts at an edge where cdone_o=1, sw_en_i=1, sw_busy_o=0 and clear_i=0. After that edge, sw_pulse_o=1, sw_busy_o=1 and cdone_o=0.
- R5: sw_pulse_o is high for exactly one cycle per switch, and sw_busy_o is high in that cycle.
- R6: sw_busy_o stays high until ROWS+COLS-1 edges with pipe_en_i=1 have passed since the start edge. Cycles with pipe_en_i=0 hold it.
- R7: clear_i=1 at an edge makes cdone_o, sw_pulse_o and sw_busy_o 0 after that edge. It also resets the MAC count to zero and discards a pending done flag, with priority over counting and starting.
- R8: The MAC count restarts from zero at the start edge. MAC cycles during the busy interval count toward the next context.
- R9: sw_en_i has no effect while cdone_o is 0: no pulse is issued.
- R10: If the next context overflows while sw_busy_o is 1, the new switch waits until sw_busy_o has returned to 0, even when sw_en_i is held high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of count, done flag and switch sequence |
| pipe_en_i | input | 1 | Pipeline enable of the array |
| soft_stall_i | input | 1 | Operands forced to zero; cycle is not a MAC |
| macs_i | input | CNT_W | MACs per context (1 or more) |
| sw_en_i | input | 1 | Switch enable from the context controller |
| cdone_o | output | 1 | Context MAC count reached |
| sw_pulse_o | output | 1 | Context switch pulse at array entry |
| sw_busy_o | output | 1 | Switch propagating through the array |

## Verification
Every output is registered, so each result appears one edge after the stimulus that causes it. cdone_o follows the qualifying MAC edge, and the pulse and busy follow the start edge. sw_busy_o falls after the ROWS+COLS-1-th pipeline-enabled edge, counted from the start edge. The bench drives inputs on the falling edge, waits one rising edge, and samples 1 ns later, so each check sees the result of exactly one edge. The busy-length test counts sampled busy cycles with the pipeline held on.

// File: rtl/ctx_sw_pkg.sv
package ctx_sw_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_PROP = 1'b1
  } seq_state_e;
endpackage

// File: rtl/mac_counter.sv
module mac_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             mac_fire_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic [CNT_W:0]   cnt_nxt;

  assign cnt_nxt = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (clear_i || restart_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (mac_fire_i && !done_q) begin
      cnt_q <= cnt_nxt[CNT_W-1:0];
      if (cnt_nxt >= {1'b0, limit_i}) done_q <= 1'b1;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/switch_sequencer.sv
module switch_sequencer
  import ctx_sw_pkg::*;
#(
  parameter int PROP   = 7,
  localparam int PROP_W = $clog2(PROP + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic req_i,
  input  logic pipe_en_i,
  output logic start_o,
  output logic pulse_o,
  output logic busy_o
);
  seq_state_e        state_q;
  logic [PROP_W-1:0] cnt_q;
  logic              pulse_q;

  assign start_o = req_i && !clear_i && (state_q == SEQ_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (clear_i) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= start_o;
      if (start_o) begin
        state_q <= SEQ_PROP;
        cnt_q   <= PROP_W'(PROP);
      end else if (state_q == SEQ_PROP && pipe_en_i) begin
        // switch front advances one diagonal per enabled cycle
        if (cnt_q == PROP_W'(1)) state_q <= SEQ_IDLE;
        cnt_q <= cnt_q - PROP_W'(1);
      end
    end
  end

  assign pulse_o = pulse_q;
  assign busy_o  = (state_q == SEQ_PROP);
endmodule

// File: rtl/ctx_switch_gen.sv
module ctx_switch_gen #(
  parameter int CNT_W = 16,
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  localparam int PROP = ROWS + COLS - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             pipe_en_i,
  input  logic             soft_stall_i,
  input  logic [CNT_W-1:0] macs_i,
  input  logic             sw_en_i,
  output logic             cdone_o,
  output logic             sw_pulse_o,
  output logic             sw_busy_o
);
  logic mac_fire;
  logic done;
  logic start;

  // corner PE accumulates only on enabled, non-zeroed cycles
  assign mac_fire = pipe_en_i && !soft_stall_i;

  mac_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear_i),
    .mac_fire_i(mac_fire),
    .restart_i (start),
    .limit_i   (macs_i),
    .done_o    (done)
  );

  switch_sequencer #(.PROP(PROP)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear_i),
    .req_i    (done && sw_en_i),
    .pipe_en_i(pipe_en_i),
    .start_o  (start),
    .pulse_o  (sw_pulse_o),
    .busy_o   (sw_busy_o)
  );

  assign cdone_o = done;
endmodule

// File: rtl/ctx_switch_gen_chk.sv
module ctx_switch_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic clear_i,
  input logic pipe_en_i,
  input logic sw_en_i,
  input logic cdone_o,
  input logic sw_pulse_o,
  input logic sw_busy_o
);
  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_pulse_o |=> !sw_pulse_o); // R5
  AST_PULSE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_pulse_o |-> sw_busy_o); // R5
  AST_START_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_pulse_o) |-> $past(cdone_o && sw_en_i && !sw_busy_o && !clear_i)); // R4
  AST_DONE_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_pulse_o |-> !cdone_o); // R4
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cdone_o && !sw_en_i && !clear_i) |=> cdone_o); // R3
  AST_BUSY_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_busy_o && !pipe_en_i && !clear_i) |=> sw_busy_o); // R6
  AST_CLEAR_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!cdone_o && !sw_busy_o && !sw_pulse_o)); // R7
  AST_WAIT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_busy_o && !sw_pulse_o) |=> !sw_pulse_o); // R10
endmodule

bind ctx_switch_gen ctx_switch_gen_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clear_i   (clear_i),
  .pipe_en_i (pipe_en_i),
  .sw_en_i   (sw_en_i),
  .cdone_o   (cdone_o),
  .sw_pulse_o(sw_pulse_o),
  .sw_busy_o (sw_busy_o)
);

// File: tb/ctx_switch_gen_test.sv
`timescale 1ns/1ps
module ctx_switch_gen_test;
  localparam int CNT_W = 8;
  localparam int ROWS  = 3;
  localparam int COLS  = 2;
  localparam int PROP  = ROWS + COLS - 1;
  localparam int NV    = 19;
  // bits: pipe_en soft_stall sw_en clear | exp cdone pulse busy ; macs=3
  localparam logic [6:0] VEC [NV] = '{
    7'b1000_000, 7'b1100_000, 7'b0000_000, 7'b1000_000, 7'b1010_100,
    7'b1000_100, 7'b0010_011, 7'b1000_001, 7'b1010_001, 7'b1010_101,
    7'b0010_101, 7'b1010_100, 7'b0010_011, 7'b1001_000, 7'b1000_000,
    7'b1000_000, 7'b1000_100, 7'b0001_000, 7'b0010_000
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic clear_i = 1'b0, pipe_en_i = 1'b0, soft_stall_i = 1'b0, sw_en_i = 1'b0;
  logic [CNT_W-1:0] macs_i = 8'd3;
  logic cdone_o, sw_pulse_o, sw_busy_o;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  ctx_switch_gen #(.CNT_W(CNT_W), .ROWS(ROWS), .COLS(COLS)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .pipe_en_i(pipe_en_i),
    .soft_stall_i(soft_stall_i), .macs_i(macs_i), .sw_en_i(sw_en_i),
    .cdone_o(cdone_o), .sw_pulse_o(sw_pulse_o), .sw_busy_o(sw_busy_o)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic pe, input logic ss, input logic en, input logic clr);
    @(negedge clk_i);
    pipe_en_i = pe; soft_stall_i = ss; sw_en_i = en; clear_i = clr;
    @(posedge clk_i);
    #1;
  endtask

  initial begin
    #1;
    check("R1", "cdone in reset", int'(cdone_o), 0);
    check("R1", "busy in reset", int'(sw_busy_o), 0);
    #20 rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = (i >= 13) ? "R7" : (i >= 7) ? "R8" : "R2";
      step(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3]);
      check(tag, $sformatf("vec %0d cdone R3", i), int'(cdone_o), int'(VEC[i][2]));
      check(tag, $sformatf("vec %0d pulse R4", i), int'(sw_pulse_o), int'(VEC[i][1]));
      check(tag, $sformatf("vec %0d busy R6", i), int'(sw_busy_o), int'(VEC[i][0]));
    end
    // R9: vector 4 applied sw_en_i before overflow; vector 10 held it during busy (R10)

    // R2: soft-stalled cycles never reach the limit
    macs_i = 8'd1;
    step(1'b0, 1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 5; k++) step(1'b1, 1'b1, 1'b0, 1'b0);
    check("R2", "cdone after soft stalls", int'(cdone_o), 0);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    check("R2", "cdone after one MAC", int'(cdone_o), 1);

    // R5, R6: busy length with pipeline held on
    begin
      int busy_cyc, pulses;
      busy_cyc = 0; pulses = 0;
      step(1'b1, 1'b1, 1'b1, 1'b0);
      check("R4", "start pulse", int'(sw_pulse_o), 1);
      while (sw_busy_o && busy_cyc < 50) begin
        busy_cyc++;
        if (sw_pulse_o) pulses++;
        step(1'b1, 1'b1, 1'b0, 1'b0);
      end
      check("R6", "busy cycles", busy_cyc, PROP);
      check("R5", "pulse count", pulses, 1);
    end

    // R1: asynchronous reset during busy
    step(1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b1, 1'b0);
    check("R4", "second start busy", int'(sw_busy_o), 1);
    #2 rst_ni = 1'b0;
    #1;
    check("R1", "busy after async reset", int'(sw_busy_o), 0);
    check("R1", "pulse after async reset", int'(sw_pulse_o), 0);
    rst_ni = 1'b1;

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule